// File: doc/BRIEF.md
# Board Platform Status and Control Register Block

This block is a small 32-bit register file that lets software discover how the board is set up and ask for a full system restart. It sits behind a simple request/response port: the initiator presents a word address, an access size, a write flag and write data with a valid signal, and the block accepts the request when its ready output is high. One cycle after acceptance it raises a response strobe together with the read data. That read data stays on the port until the next accepted read.

The status the block reports is mostly fixed. Clock-generator lock, memory calibration and the set of enabled expansion ports are presented as constant codes. Two inputs are live: the timer reference frequency in MHz, which is packed into a clock-divider word, and the installed memory size in gigabytes, which sits in a memory configuration word. Only full 32-bit accesses are honoured. One control word turns a write with a particular bit set into a one-cycle system reset request.

The window covers 4 KB, which is 1024 word slots. The port carries the word index, meaning the byte offset divided by four.

Top module: `plat_regs`

## Requirements
- R1: While rstN is low, reqReady, rspValid, sysResetReq and rspRdata are all zero. From the first clock edge after reset is released, reqReady is high. A request is accepted on a clock edge where reqValid and reqReady are both high, and rspValid is high for exactly the cycle that follows each accepted request.
- R2: A word read at word index 0, 1 or 2 (build identifier and the two revision words) returns 0x00000000.
- R3: A word read at word index 5 (memory status) returns 0x00000005. Bit 0 is clock locked, bit 2 is calibration done, and every other bit is clear.
- R4: A word read at word index 12 (clock divider) returns the following fields: bits 7:0 are the clock-0 divide (1), bits 15:8 are the value of timerMhz, bits 23:16 are the multiplier (1) and bits 31:24 are the clock-1 divide (1).
- R5: A word read at word index 13 (build configuration) returns 0x0000000E. Bits 1 to 3 mark three expansion ports as enabled, and bit 0, the coherence unit flag, is clear.
- R6: A word read at word index 14 (memory configuration) returns memGb in bits 3:0, ones in bits 15:4 and zeros in bits 31:16.
- R7: A word read at any other index returns zero. This includes index 4 (the reset control word), index 6 (expansion link status) and the top of the window (1023).
- R8: reqSize encodes the access size as follows: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. Any read whose size is not 2 returns zero. Any write whose size is not 2 produces no reset request.
- R9: An accepted 4-byte write at index 4 with reqWdata bit 4 set raises sysResetReq for exactly the cycle that follows acceptance. The same write with bit 4 clear produces no pulse.
- R10: Writes to any index other than 4 have no effect. They produce no pulse, and later reads of every register return the same values as before.
- R11: rspRdata changes only on the cycle after an accepted read. It holds its value through idle cycles and accepted writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 10 | Word index within the 4 KB window |
| reqSize | input | 2 | Access size code (R8) |
| reqWdata | input | 32 | Write data |
| timerMhz | input | 8 | Timer reference frequency in MHz |
| memGb | input | 4 | Installed memory size in GB |
| rspValid | output | 1 | Response strobe, one cycle after acceptance |
| rspRdata | output | 32 | Read data, held until the next accepted read |
| sysResetReq | output | 1 | One-cycle system reset request |

## Verification
The hardest case to reach from the ports is when one response cycle mixes a reset pulse, held read data and a new request. This happens when a reset write is followed immediately by a read and then by a write at a different size. The stimulus issues back-to-back requests with no idle cycle between them, and it interleaves wrong-size and read-only writes between reads. This shows that neither the pulse nor the held data leaks into the neighbouring access. The live inputs timerMhz and memGb are changed between reads, which shows that the divider and memory words follow them rather than a captured value.

// File: rtl/plat_regs_pkg.sv
package plat_regs_pkg;
  localparam int DATA_W   = 32;
  localparam int MHZ_W    = 8;
  localparam int GB_W     = 4;
  localparam int RST_BIT  = 4;

  localparam logic [DATA_W-1:0] RST_MASK    = DATA_W'(1) << RST_BIT;
  localparam logic [DATA_W-1:0] MEMSTAT_VAL = 32'h0000_0005;
  localparam logic [DATA_W-1:0] BUILD_VAL   = 32'h0000_000E;

  localparam int IDX_RSTCTL  = 4;
  localparam int IDX_MEMSTAT = 5;
  localparam int IDX_CLKDIV  = 12;
  localparam int IDX_BUILD   = 13;
  localparam int IDX_MEMCFG  = 14;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_MEMSTAT,
    SEL_CLKDIV,
    SEL_BUILD,
    SEL_MEMCFG
  } regSel_e;

  typedef struct packed {
    logic    rdLoad;
    logic    rstFire;
    regSel_e sel;
  } ctlStrobe_t;
endpackage

// File: rtl/plat_regs_ctrl.sv
module plat_regs_ctrl
  import plat_regs_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output ctlStrobe_t        strobe
);
  logic    readyQ;
  logic    accept;
  logic    sizeOk;
  logic    rstHit;
  regSel_e decodeSel;

  assign accept   = reqValid && readyQ;
  assign sizeOk   = (accSize_e'(reqSize) == SZ_WORD);
  assign rstHit   = (reqWdata & RST_MASK) != '0;
  assign reqReady = readyQ;

  always_comb begin
    decodeSel = SEL_ZERO;
    if (sizeOk) begin
      case (reqAddr)
        IDX_W'(IDX_MEMSTAT): decodeSel = SEL_MEMSTAT;
        IDX_W'(IDX_CLKDIV):  decodeSel = SEL_CLKDIV;
        IDX_W'(IDX_BUILD):   decodeSel = SEL_BUILD;
        IDX_W'(IDX_MEMCFG):  decodeSel = SEL_MEMCFG;
        default:             decodeSel = SEL_ZERO;
      endcase
    end
  end

  always_comb begin
    strobe.rdLoad  = accept && !reqWrite;
    strobe.rstFire = accept && reqWrite && sizeOk &&
                     (reqAddr == IDX_W'(IDX_RSTCTL)) && rstHit;
    strobe.sel     = decodeSel;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyQ   <= 1'b0;
      rspValid <= 1'b0;
    end else begin
      readyQ   <= 1'b1;
      rspValid <= accept;
    end
  end

  p_rsp_follows_accept_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady));
  p_no_fire_without_word_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rstFire |-> (reqSize == 2'd2));
endmodule

// File: rtl/plat_regs_dp.sv
module plat_regs_dp
  import plat_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [MHZ_W-1:0]  timerMhz,
  input  logic [GB_W-1:0]   memGb,
  output logic [DATA_W-1:0] rspRdata,
  output logic              sysResetReq
);
  logic [DATA_W-1:0] clkDivWord;
  logic [DATA_W-1:0] memCfgWord;
  logic [DATA_W-1:0] rdValue;

  assign clkDivWord = {8'd1, 8'd1, timerMhz, 8'd1};
  assign memCfgWord = {16'h0000, 12'hFFF, memGb};

  always_comb begin
    case (strobe.sel)
      SEL_MEMSTAT: rdValue = MEMSTAT_VAL;
      SEL_CLKDIV:  rdValue = clkDivWord;
      SEL_BUILD:   rdValue = BUILD_VAL;
      SEL_MEMCFG:  rdValue = memCfgWord;
      default:     rdValue = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspRdata    <= '0;
      sysResetReq <= 1'b0;
    end else begin
      sysResetReq <= strobe.rstFire;
      if (strobe.rdLoad) rspRdata <= rdValue;
    end
  end

  p_hold_without_read_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdLoad |=> $stable(rspRdata));
endmodule

// File: rtl/plat_regs.sv
module plat_regs
  import plat_regs_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [31:0]       reqWdata,
  input  logic [7:0]        timerMhz,
  input  logic [3:0]        memGb,
  output logic              rspValid,
  output logic [31:0]       rspRdata,
  output logic              sysResetReq
);
  ctlStrobe_t strobe;

  plat_regs_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  plat_regs_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .timerMhz(timerMhz),
    .memGb(memGb), .rspRdata(rspRdata), .sysResetReq(sysResetReq)
  );

  p_pulse_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> $past(reqValid && reqReady && reqWrite && reqSize == 2'd2 &&
                          reqAddr == IDX_W'(IDX_RSTCTL) && reqWdata[RST_BIT]));
  p_pulse_gives_rsp_r9: assert property (@(posedge clk) disable iff (!rstN)
    sysResetReq |-> rspValid);
  p_bad_size_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite && reqSize != 2'd2) |=> (rspRdata == '0));
  p_memstat_code_r3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !reqWrite && reqSize == 2'd2 &&
     reqAddr == IDX_W'(IDX_MEMSTAT)) |=> (rspRdata == 32'h5));
  p_write_keeps_data_r11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqWrite) |=> $stable(rspRdata));
endmodule

// File: tb/tb_plat_regs.sv
module tb_plat_regs;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [9:0]  reqAddr = '0;
  logic [1:0]  reqSize = 2'd2;
  logic [31:0] reqWdata = '0;
  logic [7:0]  timerMhz = 8'd50;
  logic [3:0]  memGb = 4'd1;
  logic        reqReady, rspValid, sysResetReq;
  logic [31:0] rspRdata;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 0;

  // reference model state
  bit          mReady = 0, mValid = 0, mPulse = 0;
  logic [31:0] mData = '0;
  string       mTag = "R1";

  always #5 clk = ~clk;

  plat_regs dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqSize(reqSize),
    .reqWdata(reqWdata), .timerMhz(timerMhz), .memGb(memGb),
    .rspValid(rspValid), .rspRdata(rspRdata), .sysResetReq(sysResetReq)
  );

  function automatic logic [31:0] regValue(int idx, logic [7:0] mhz, logic [3:0] gb);
    if (idx == 5)  return 32'h0000_0005;
    if (idx == 12) return {8'd1, 8'd1, mhz, 8'd1};
    if (idx == 13) return 32'h0000_000E;
    if (idx == 14) return {16'h0, 12'hFFF, gb};
    return 32'h0;
  endfunction

  function automatic string tagFor(bit wr, int idx, logic [1:0] sz);
    if (sz != 2'd2) return "R8";
    if (wr) return (idx == 4) ? "R9" : "R10";
    if (idx <= 2) return "R2";
    if (idx == 5) return "R3";
    if (idx == 12) return "R4";
    if (idx == 13) return "R5";
    if (idx == 14) return "R6";
    return "R7";
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mReady = 0; mValid = 0; mPulse = 0; mData = '0; mTag = "R1";
    end else begin
      bit acc;
      acc = reqValid && mReady;
      mValid = acc;
      mPulse = acc && reqWrite && reqSize == 2'd2 && reqAddr == 10'd4 && reqWdata[4];
      if (acc && !reqWrite)
        mData = (reqSize == 2'd2) ? regValue(int'(reqAddr), timerMhz, memGb) : 32'h0;
      mTag = acc ? tagFor(reqWrite, int'(reqAddr), reqSize) : "R11";
      mReady = 1;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cycles++;
      checks++;
      if (reqReady !== mReady || rspValid !== mValid ||
          sysResetReq !== mPulse || rspRdata !== mData) begin
        fails++;
        $display("FAIL %s: ready/valid/pulse/data = %0b/%0b/%0b/%h expected %0b/%0b/%0b/%h",
                 mTag, reqReady, rspValid, sysResetReq, rspRdata,
                 mReady, mValid, mPulse, mData);
      end
      if (cycles > 5000) begin
        fails++;
        $display("FAIL watchdog: cycles %0d expected below 5000", cycles);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    end
  end

  task automatic access(bit wr, int idx, logic [1:0] sz, logic [31:0] wd, int gap);
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = 10'(idx); reqSize = sz; reqWdata = wd;
    if (gap > 0) begin
      @(negedge clk);
      reqValid = 0;
      repeat (gap - 1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);   // R1 reset state compared every cycle
    rstN = 1;
    // R2..R7: every low word, back to back
    for (int i = 0; i < 16; i++) access(0, i, 2'd2, 0, 0);
    access(0, 1023, 2'd2, 0, 2);           // R7 top of window
    timerMhz = 8'd125; memGb = 4'd2;
    access(0, 12, 2'd2, 0, 1);             // R4 live frequency
    access(0, 14, 2'd2, 0, 1);             // R6 live size
    // R8 wrong sizes
    for (int s = 0; s < 4; s++) if (s != 2) access(0, 5, 2'(s), 0, 1);
    access(0, 13, 2'd2, 0, 0);
    access(1, 4, 2'd0, 32'hFFFF_FFFF, 0);  // R8 no pulse
    access(1, 4, 2'd3, 32'h10, 2);
    // R9 pulse then immediate read
    access(1, 4, 2'd2, 32'h10, 0);
    access(0, 12, 2'd2, 0, 0);
    access(1, 4, 2'd2, 32'hFFFF_FFEF, 1);  // bit 4 clear
    access(1, 4, 2'd2, 32'h0000_0010, 0);
    access(1, 4, 2'd2, 32'h0000_0010, 1);  // back-to-back pulses
    // R10 read-only writes then readback
    for (int i = 0; i < 16; i++) if (i != 4) access(1, i, 2'd2, 32'hFFFF_FFFF, 0);
    access(1, 700, 2'd2, 32'h10, 0);
    for (int i = 0; i < 16; i++) access(0, i, 2'd2, 0, 0);
    timerMhz = 8'd0; memGb = 4'd15;
    access(0, 12, 2'd2, 0, 0);
    access(0, 14, 2'd2, 0, 3);             // R11 hold over idles
    access(1, 13, 2'd2, 32'h0, 3);         // R11 hold over write
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule